// File: doc/BRIEF.md
# Three-State PWM Input Classifier

This block turns a sampled digital code of a PWM input voltage into the two signals a gate-drive controller needs: a clean logic level and a qualified three-state (shutdown) flag. A new code arrives on every clock, typically an 8-bit converter word where full scale is 5 V, so one code step is about 19.6 mV.

The input is decoded into three levels. Two logic thresholds, at about 3.55 V and 1.15 V, recognise a definite high or low. Two window thresholds, at about 3.45 V and 1.25 V, sit just inside them, so a confirmed level is only abandoned once the input moves clearly into the middle. An input that stays in the middle region for a programmable hold-off count of clock cycles is reported as a valid three-state condition; a floating input settles near 2.5 V and lands there. A crossing of either logic threshold ends the hold-off or the three-state condition immediately, and the level output follows on the next clock.

With default parameters the thresholds are codes 181, 176, 64 and 59 and the hold-off is 18 cycles (180 ns at 100 MHz). From reset the block reports a valid three-state condition, so nothing downstream switches before a defined level appears.

Top module: `tristate_pwm_classifier`

## Requirements
- R1: While rst_ni is low and after it rises, until the first level crossing, tristate_valid_o is 1 and pwm_level_o is 0.
- R2: A code greater than or equal to HI_TH (default 181), in any state, makes pwm_level_o 1 and tristate_valid_o 0 after the next rising clock edge.
- R3: A code less than or equal to LO_TH (default 59), in any state, makes pwm_level_o 0 and tristate_valid_o 0 after the next rising clock edge.
- R4: With a confirmed high (pwm_level_o 1, no hold-off running), codes from TRI_HI_TH (default 176) upward keep the high and start no hold-off.
- R5: With a confirmed low, codes up to TRI_LO_TH (default 64) keep the low and start no hold-off.
- R6: From a confirmed level, a code strictly between TRI_LO_TH and TRI_HI_TH starts the hold-off; tristate_valid_o rises at the clock edge that takes the HOLD_CYC-th consecutive sample strictly between LO_TH and HI_TH, and not earlier.
- R7: While the hold-off runs, every code strictly between LO_TH and HI_TH, including the hysteresis bands, counts toward it, and pwm_level_o keeps the last confirmed level.
- R8: A logic-threshold crossing before the hold-off expires cancels it; a later window entry needs a full HOLD_CYC samples again.
- R9: While tristate_valid_o is 1, codes strictly between LO_TH and HI_TH keep it at 1 and leave pwm_level_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; one code sample per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W | Sampled code of the PWM input voltage |
| pwm_level_o | output | 1 | Last confirmed logic level |
| tristate_valid_o | output | 1 | Qualified three-state condition |

## Verification
The hardest case to reach is a hold-off that runs through codes in the hysteresis bands: once counting, a code between the window and logic thresholds must keep counting, while the same code from a confirmed level must not start a count. The stimulus enters the window, steps into the band near the lower or upper logic threshold partway through, and expects the flag on exactly the HOLD_CYC-th sample. A second sequence leaves the window early, re-enters, and expects a full fresh count, which shows that a cancelled hold-off leaves no residue.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_HIGH = 2'd1,
    ST_PEND = 2'd2,
    ST_TRI  = 2'd3
  } tsc_state_e;

  localparam int unsigned CMP_N      = 4;
  localparam int unsigned CMP_HI     = 0;  // code >= HI_TH
  localparam int unsigned CMP_TRI_HI = 1;  // code >= TRI_HI_TH
  localparam int unsigned CMP_TRI_LO = 2;  // code <= TRI_LO_TH
  localparam int unsigned CMP_LO     = 3;  // code <= LO_TH
endpackage

// File: rtl/tsc_thresh_cmp.sv
module tsc_thresh_cmp #(
  parameter int unsigned                        CODE_W  = 8,
  parameter int unsigned                        N       = 4,
  parameter logic [N*CODE_W-1:0]                TH_VEC  = '0,
  parameter logic [N-1:0]                       GE_MASK = '0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [N-1:0]      hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    localparam logic [CODE_W-1:0] TH = TH_VEC[g*CODE_W +: CODE_W];
    if (GE_MASK[g]) begin : g_ge
      assign hit_o[g] = (code_i >= TH);
    end else begin : g_le
      assign hit_o[g] = (code_i <= TH);
    end
  end
endmodule

// File: rtl/tsc_holdoff_cnt.sv
module tsc_holdoff_cnt #(
  parameter int unsigned HOLD_CYC = 18,
  localparam int unsigned CNT_W   = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic inc_i,
  output logic hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  // count including the sample taken this cycle
  assign cnt_nxt = start_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign hit_o   = (cnt_nxt >= CNT_W'(HOLD_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i || inc_i) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tsc_level_fsm.sv
module tsc_level_fsm
  import tsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ge_hi_i,
  input  logic       ge_tri_hi_i,
  input  logic       le_tri_lo_i,
  input  logic       le_lo_i,
  input  logic       cnt_hit_i,
  output logic       cnt_start_o,
  output logic       cnt_inc_o,
  output tsc_state_e st_o,
  output logic       level_o
);
  tsc_state_e st_q, st_d;
  logic       lvl_q, lvl_d;

  always_comb begin
    st_d        = st_q;
    lvl_d       = lvl_q;
    cnt_start_o = 1'b0;
    cnt_inc_o   = 1'b0;
    if (ge_hi_i) begin
      st_d  = ST_HIGH;
      lvl_d = 1'b1;
    end else if (le_lo_i) begin
      st_d  = ST_LOW;
      lvl_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_HIGH: if (!ge_tri_hi_i) begin
          cnt_start_o = 1'b1;
          st_d        = cnt_hit_i ? ST_TRI : ST_PEND;
        end
        ST_LOW: if (!le_tri_lo_i) begin
          cnt_start_o = 1'b1;
          st_d        = cnt_hit_i ? ST_TRI : ST_PEND;
        end
        ST_PEND: begin
          cnt_inc_o = 1'b1;
          if (cnt_hit_i) st_d = ST_TRI;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_TRI;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign st_o    = st_q;
  assign level_o = lvl_q;
endmodule

// File: rtl/tristate_pwm_classifier.sv
module tristate_pwm_classifier
  import tsc_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned HI_TH     = 181,
  parameter int unsigned TRI_HI_TH = 176,
  parameter int unsigned TRI_LO_TH = 64,
  parameter int unsigned LO_TH     = 59,
  parameter int unsigned HOLD_CYC  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              pwm_level_o,
  output logic              tristate_valid_o
);
  localparam logic [CMP_N*CODE_W-1:0] TH_VEC =
    {CODE_W'(LO_TH), CODE_W'(TRI_LO_TH), CODE_W'(TRI_HI_TH), CODE_W'(HI_TH)};
  localparam logic [CMP_N-1:0] GE_MASK = 4'b0011;

  logic [CMP_N-1:0] cmp;
  logic             cnt_start, cnt_inc, cnt_hit;
  tsc_state_e       st;
  logic             pend;

  tsc_thresh_cmp #(
    .CODE_W (CODE_W),
    .N      (CMP_N),
    .TH_VEC (TH_VEC),
    .GE_MASK(GE_MASK)
  ) u_cmp (
    .code_i(code_i),
    .hit_o (cmp)
  );

  tsc_holdoff_cnt #(
    .HOLD_CYC(HOLD_CYC)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cnt_start),
    .inc_i  (cnt_inc),
    .hit_o  (cnt_hit)
  );

  tsc_level_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ge_hi_i    (cmp[CMP_HI]),
    .ge_tri_hi_i(cmp[CMP_TRI_HI]),
    .le_tri_lo_i(cmp[CMP_TRI_LO]),
    .le_lo_i    (cmp[CMP_LO]),
    .cnt_hit_i  (cnt_hit),
    .cnt_start_o(cnt_start),
    .cnt_inc_o  (cnt_inc),
    .st_o       (st),
    .level_o    (pwm_level_o)
  );

  assign tristate_valid_o = (st == ST_TRI);
  assign pend             = (st == ST_PEND);
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned HI_TH     = 181,
  parameter int unsigned TRI_HI_TH = 176,
  parameter int unsigned TRI_LO_TH = 64,
  parameter int unsigned LO_TH     = 59,
  parameter int unsigned HOLD_CYC  = 18,
  localparam int unsigned RUN_W    = $clog2(HOLD_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pwm_level_o,
  input  logic              tristate_valid_o,
  input  logic              pend_i
);
  logic             mid;
  logic [RUN_W-1:0] run_q;

  assign mid = (code_i > CODE_W'(LO_TH)) && (code_i < CODE_W'(HI_TH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (!mid)                      run_q <= '0;
    else if (run_q < RUN_W'(HOLD_CYC))  run_q <= run_q + RUN_W'(1);
  end

  AST_HI_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_i >= CODE_W'(HI_TH) |=> pwm_level_o && !tristate_valid_o);  // R2
  AST_LO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_i <= CODE_W'(LO_TH) |=> !pwm_level_o && !tristate_valid_o);  // R3
  AST_HI_HYST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_level_o && !tristate_valid_o && !pend_i && code_i >= CODE_W'(TRI_HI_TH)
    |=> pwm_level_o && !tristate_valid_o && !pend_i);  // R4
  AST_LO_HYST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_level_o && !tristate_valid_o && !pend_i && code_i <= CODE_W'(TRI_LO_TH)
    |=> !pwm_level_o && !tristate_valid_o && !pend_i);  // R5
  AST_NO_EARLY_TRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tristate_valid_o) |-> run_q >= RUN_W'(HOLD_CYC));  // R6
  AST_LEVEL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid |=> $stable(pwm_level_o));  // R7
  AST_TRI_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tristate_valid_o && mid |=> tristate_valid_o);  // R9
endmodule

bind tristate_pwm_classifier tsc_checker #(
  .CODE_W   (CODE_W),
  .HI_TH    (HI_TH),
  .TRI_HI_TH(TRI_HI_TH),
  .TRI_LO_TH(TRI_LO_TH),
  .LO_TH    (LO_TH),
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .code_i          (code_i),
  .pwm_level_o     (pwm_level_o),
  .tristate_valid_o(tristate_valid_o),
  .pend_i          (pend)
);

// File: tb/tristate_pwm_classifier_tb_top.sv
module tristate_pwm_classifier_tb_top;
  localparam int unsigned HOLD = 18;

  typedef struct {
    logic  lvl;
    logic  tv;
    string tag;
    int    code;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = 8'd128;
  logic       lvl_o, tv_o;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  tristate_pwm_classifier dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .code_i          (code),
    .pwm_level_o     (lvl_o),
    .tristate_valid_o(tv_o)
  );

  task automatic cmp(input logic lvl, input logic tv, input string tag, input int c);
    checks++;
    if (lvl_o !== lvl || tv_o !== tv) begin
      errors++;
      $display("FAIL %s code=%0d: level=%b tri=%b expected level=%b tri=%b",
               tag, c, lvl_o, tv_o, lvl, tv);
    end
  endtask

  task automatic step(input int c, input logic lvl, input logic tv, input string tag);
    exp_t e;
    @(negedge clk);
    code = 8'(c);
    e.lvl = lvl; e.tv = tv; e.tag = tag; e.code = c;
    q.push_back(e);
  endtask

  // monitor: each edge consumes the item driven before it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.lvl, e.tv, e.tag, e.code);
      end
    end
  end

  initial begin
    #3;
    cmp(1'b0, 1'b1, "R1 in reset", 128);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R9: reset state holds for mid codes, incl. codes just inside logic thresholds
    for (int i = 0; i < 5; i++) step(128, 0, 1, "R1");
    step(180, 0, 1, "R9");
    step(60, 0, 1, "R9");
    step(181, 1, 0, "R2");
    // R4: upper hysteresis band
    step(176, 1, 0, "R4");
    step(180, 1, 0, "R4");
    step(200, 1, 0, "R4");
    // R6: full hold-off from high
    for (int i = 1; i <= HOLD; i++) step(i == 1 ? 175 : 128, 1, i >= HOLD, "R6");
    step(150, 1, 1, "R9");
    step(59, 0, 0, "R3");
    // R5: lower hysteresis band
    step(64, 0, 0, "R5");
    step(60, 0, 0, "R5");
    // R8: early exit to opposite level
    for (int i = 1; i <= 10; i++) step(i == 1 ? 65 : 100, 0, 0, "R7");
    step(181, 1, 0, "R8");
    // R8: early exit to same level, then fresh full count
    for (int i = 1; i <= 5; i++) step(175, 1, 0, "R7");
    step(200, 1, 0, "R8");
    for (int i = 1; i <= HOLD; i++) step(128, 1, i >= HOLD, "R8");
    step(58, 0, 0, "R3");
    step(255, 1, 0, "R2");
    step(0, 0, 0, "R3");
    // R7: hold-off continues through lower band
    for (int i = 1; i <= HOLD; i++) step(i <= 10 ? 100 : 62, 0, i >= HOLD, "R7");
    step(181, 1, 0, "R2");
    // R7: hold-off continues through upper band
    for (int i = 1; i <= HOLD; i++) step(i <= 5 ? 175 : 179, 1, i >= HOLD, "R7");
    step(176, 1, 1, "R9");
    step(59, 0, 0, "R3");

    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule